// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 32 interrupt inputs and drives two request lines into a processor: a normal request line shared by sources 1 to 31 and a fast request line owned by source 0 alone. Each source is programmed over a simple register bus with a trigger kind, a 3-bit priority and a 32-bit vector. Inputs pass through a two-flop synchronizer. Level sources follow the synchronized input. Edge sources set a sticky pending bit.

Service starts when software reads the acknowledge register. That read returns the vector of the winning source, records the source as current and pushes its priority onto an internal 8-entry level stack. This drops the normal request until a source of strictly higher priority arrives, which allows nesting. A write to the end-of-service register pops one level. If the acknowledge read finds nothing eligible, the block returns a programmable spurious vector and pushes nothing.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both request lines are low, and the mask, the edge-latched pending bits, the level stack, every mode word, every vector and the spurious vector all read zero.
- R2: The command words at 0x120 (enable), 0x124 (disable), 0x128 (clear pending) and 0x12C (set pending) act only on the bit positions written as 1. Zero bits have no effect. The mask reads at 0x110 and the pending set at 0x10C.
- R3: The mode word of source n sits at 4*n, with the trigger in bits [6:5]: 0 low level, 1 falling edge, 2 high level, 3 rising edge. A level source is pending while its synchronized input matches. An edge source latches pending on the matching transition and stays pending until it is cleared.
- R4: The priority sits in mode bits [2:0], where 7 is the most urgent. Among eligible (pending and enabled) sources 1 to 31, the highest priority wins, and ties go to the lowest source number.
- R5: A read of 0x100 while the normal line is high returns the winner's vector (word at 0x80+4*n), clears that source's edge latch and drops the normal line.
- R6: The normal line is high only when some source wins with a priority strictly above the top of the level stack, or the stack is empty. The status word at 0x108 gives the current source number in bits [4:0].
- R7: Any write to 0x130 pops one stack level, so the status shows the previous source and a waiting source may raise the normal line again.
- R8: A read of 0x100 while the normal line is low returns the word at 0x134, sets the status to 0 and leaves the stack untouched. The next end-of-service write only clears that spurious state and pops nothing.
- R9: Source 0 drives only the fast line (pending and enabled). A read of 0x104 returns its vector while the fast line is high, otherwise the spurious word, and clears its edge latch.
- R10: The word at 0x114 shows the live fast line in bit 0 and the live normal line in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write strobe for one cycle |
| rdEn | input | 1 | Register read strobe; read side effects apply at the clock edge |
| addr | input | 9 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid combinationally while addr is held |
| srcIn | input | 32 | Asynchronous interrupt source inputs |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
A corrupted stack pointer or stack entry shows up at the first status read after an acknowledge or end-of-service write. The wrong source number appears there, or the normal line rises or stays low against the strict-priority rule within one cycle. Errors in the winner selection surface in the vector returned by the very acknowledge read. Errors in the edge latches show up as a request that persists after the acknowledge, or one that never appears within four cycles of an input transition. Spurious handling is checked by nesting a spurious acknowledge inside a real one and confirming that the outer source survives the following end-of-service write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC  = 32;
  localparam int IDW   = $clog2(NSRC);
  localparam int PRW   = 3;
  localparam int VW    = 32;
  localparam int AW    = 9;
  localparam int DEPTH = 8;

  localparam logic [AW-1:0] OFS_VEC  = 9'h080;
  localparam logic [AW-1:0] OFS_ACK  = 9'h100;
  localparam logic [AW-1:0] OFS_FACK = 9'h104;
  localparam logic [AW-1:0] OFS_STAT = 9'h108;
  localparam logic [AW-1:0] OFS_PEND = 9'h10C;
  localparam logic [AW-1:0] OFS_MASK = 9'h110;
  localparam logic [AW-1:0] OFS_CORE = 9'h114;
  localparam logic [AW-1:0] OFS_EN   = 9'h120;
  localparam logic [AW-1:0] OFS_DIS  = 9'h124;
  localparam logic [AW-1:0] OFS_CLR  = 9'h128;
  localparam logic [AW-1:0] OFS_SET  = 9'h12C;
  localparam logic [AW-1:0] OFS_EOI  = 9'h130;
  localparam logic [AW-1:0] OFS_SPUR = 9'h134;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_RISE = 2'd3
  } trigT;

  typedef struct packed {
    trigT           trig;
    logic [PRW-1:0] prio;
  } modeT;

  // strobes from the arbiter into the register datapath
  typedef struct packed {
    logic           ackClr;
    logic [IDW-1:0] ackId;
    logic           fastClr;
  } ctrlStrobeT;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NSRC_P = NSRC
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [AW-1:0]               addr,
  input  logic [VW-1:0]               wrData,
  input  logic [NSRC_P-1:0]           srcIn,
  input  ctrlStrobeT                  strb,
  input  logic                        irqLine,
  input  logic [IDW-1:0]              winId,
  input  logic [IDW-1:0]              statusId,
  output logic [VW-1:0]               rdData,
  output logic [NSRC_P-1:0]           eligible,
  output logic [NSRC_P-1:0][PRW-1:0]  prioVec,
  output logic                        fiqOut
);
  localparam int IW = $clog2(NSRC_P);

  modeT              modeReg [NSRC_P];
  logic [VW-1:0]     vecReg  [NSRC_P];
  logic [VW-1:0]     spurReg;
  logic [NSRC_P-1:0] maskReg, latchReg;
  logic [NSRC_P-1:0] sync1, sync2, prevIn;
  logic [NSRC_P-1:0] lvlAct, edgeHit, pendVec;
  logic [NSRC_P-1:0] enBits, disBits, setBits, clrBits, ackBits;
  logic [IW-1:0]     regIdx;

  assign regIdx = addr[IW+1:2];

  for (genvar g = 0; g < NSRC_P; g++) begin : g_src
    always_comb begin
      lvlAct[g]  = 1'b0;
      edgeHit[g] = 1'b0;
      unique case (modeReg[g].trig)
        TRIG_LOW:  lvlAct[g]  = ~sync2[g];
        TRIG_FALL: edgeHit[g] = ~sync2[g] & prevIn[g];
        TRIG_HIGH: lvlAct[g]  = sync2[g];
        default:   edgeHit[g] = sync2[g] & ~prevIn[g];
      endcase
    end
    assign prioVec[g] = modeReg[g].prio;
    assign ackBits[g] = (strb.ackClr && strb.ackId == IW'(g)) || (g == 0 && strb.fastClr);
  end

  assign pendVec  = latchReg | lvlAct;
  assign eligible = pendVec & maskReg;
  assign fiqOut   = eligible[0];

  assign enBits  = (wrEn && addr == OFS_EN)  ? wrData[NSRC_P-1:0] : '0;
  assign disBits = (wrEn && addr == OFS_DIS) ? wrData[NSRC_P-1:0] : '0;
  assign setBits = (wrEn && addr == OFS_SET) ? wrData[NSRC_P-1:0] : '0;
  assign clrBits = (wrEn && addr == OFS_CLR) ? wrData[NSRC_P-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1    <= '0;
      sync2    <= '0;
      prevIn   <= '0;
      maskReg  <= '0;
      latchReg <= '0;
      spurReg  <= '0;
      for (int i = 0; i < NSRC_P; i++) begin
        modeReg[i] <= '{trig: TRIG_LOW, prio: '0};
        vecReg[i]  <= '0;
      end
    end else begin
      sync1    <= srcIn;
      sync2    <= sync1;
      prevIn   <= sync2;
      maskReg  <= (maskReg | enBits) & ~disBits;
      latchReg <= (latchReg & ~clrBits & ~ackBits) | setBits | edgeHit;
      if (wrEn) begin
        if (addr < OFS_VEC)
          modeReg[regIdx] <= '{trig: trigT'(wrData[6:5]), prio: wrData[PRW-1:0]};
        else if (addr < OFS_ACK)
          vecReg[regIdx] <= wrData;
        else if (addr == OFS_SPUR)
          spurReg <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addr < OFS_VEC)
      rdData = VW'({modeReg[regIdx].trig, 2'b00, modeReg[regIdx].prio});
    else if (addr < OFS_ACK)
      rdData = vecReg[regIdx];
    else begin
      case (addr)
        OFS_ACK:  rdData = irqLine ? vecReg[winId] : spurReg;
        OFS_FACK: rdData = fiqOut ? vecReg[0] : spurReg;
        OFS_STAT: rdData = VW'(statusId);
        OFS_PEND: rdData = VW'(pendVec);
        OFS_MASK: rdData = VW'(maskReg);
        OFS_CORE: rdData = VW'({irqLine, fiqOut});
        OFS_SPUR: rdData = spurReg;
        default:  rdData = '0;
      endcase
    end
  end

  // R2
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_DIS) |=> ((maskReg & $past(wrData[NSRC_P-1:0])) == '0));
  // R2
  zero_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_EN && wrData[NSRC_P-1:0] == '0) |=> $stable(maskReg));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NSRC_P  = NSRC,
  parameter int DEPTH_P = DEPTH
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [AW-1:0]               addr,
  input  logic [NSRC_P-1:0]           eligible,
  input  logic [NSRC_P-1:0][PRW-1:0]  prioVec,
  output ctrlStrobeT                  strb,
  output logic                        irqOut,
  output logic [IDW-1:0]              winId,
  output logic [IDW-1:0]              statusId
);
  localparam int IW = $clog2(NSRC_P);
  localparam int SW = $clog2(DEPTH_P);
  localparam int PW = $clog2(DEPTH_P + 1);

  logic [PRW-1:0] stkPrio [DEPTH_P];
  logic [IW-1:0]  stkId   [DEPTH_P];
  logic [PW-1:0]  ptr;
  logic [SW-1:0]  topIdx;
  logic           spurFlag, winValid, ackRd, eoi, push, pop;
  logic [PRW-1:0] winPrio;

  always_comb begin
    winValid = 1'b0;
    winId    = '0;
    winPrio  = '0;
    for (int i = NSRC_P - 1; i >= 1; i--) begin
      if (eligible[i] && (!winValid || prioVec[i] >= winPrio)) begin
        winValid = 1'b1;
        winId    = IW'(i);
        winPrio  = prioVec[i];
      end
    end
  end

  assign topIdx   = SW'(ptr - 1'b1);
  assign irqOut   = winValid && (ptr == '0 || winPrio > stkPrio[topIdx]);
  assign ackRd    = rdEn && addr == OFS_ACK;
  assign eoi      = wrEn && addr == OFS_EOI;
  assign push     = ackRd && irqOut;
  assign pop      = eoi && ptr != '0 && !spurFlag;
  assign statusId = (ptr == '0 || spurFlag) ? '0 : stkId[topIdx];

  assign strb.ackClr  = push;
  assign strb.ackId   = winId;
  assign strb.fastClr = rdEn && addr == OFS_FACK && eligible[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      spurFlag <= 1'b0;
      for (int i = 0; i < DEPTH_P; i++) begin
        stkPrio[i] <= '0;
        stkId[i]   <= '0;
      end
    end else begin
      if (push) begin
        stkPrio[SW'(ptr)] <= winPrio;
        stkId[SW'(ptr)]   <= winId;
        ptr               <= ptr + 1'b1;
        spurFlag          <= 1'b0;
      end else if (ackRd) begin
        spurFlag <= 1'b1;
      end else if (eoi) begin
        spurFlag <= 1'b0;
        if (pop) ptr <= ptr - 1'b1;
      end
    end
  end

  // R6
  stack_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (ptr < PW'(DEPTH_P)));
  // R8
  spur_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && !irqOut) |=> $stable(ptr));
  // R8
  spur_eoi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoi && spurFlag && !ackRd) |=> $stable(ptr));
  // R7
  eoi_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoi && !ackRd && ptr != '0 && !spurFlag) |=> (ptr == PW'($past(ptr) - 1'b1)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [8:0]    addr,
  input  logic [31:0]   wrData,
  output logic [31:0]   rdData,
  input  logic [31:0]   srcIn,
  output logic          irqOut,
  output logic          fiqOut
);
  ctrlStrobeT                strb;
  logic [NSRC-1:0]           eligible;
  logic [NSRC-1:0][PRW-1:0]  prioVec;
  logic [IDW-1:0]            winId, statusId;

  irqc_regs #(.NSRC_P(NSRC)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .srcIn(srcIn), .strb(strb), .irqLine(irqOut), .winId(winId),
    .statusId(statusId), .rdData(rdData), .eligible(eligible),
    .prioVec(prioVec), .fiqOut(fiqOut)
  );

  irqc_arbiter #(.NSRC_P(NSRC), .DEPTH_P(DEPTH)) u_arb (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .eligible(eligible), .prioVec(prioVec), .strb(strb),
    .irqOut(irqOut), .winId(winId), .statusId(statusId)
  );

  // R9
  fast_own_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fiqOut && !irqOut) |=> !(irqOut && eligible[NSRC-1:1] == '0));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] srcIn = '0;
  logic        irqOut, fiqOut;
  int          nChecks = 0;
  int          nFails = 0;

  localparam logic [31:0] SPUR = 32'h0000_DEAD;

  // {source pattern, expected vector}; sources are high-level, priority n%8
  localparam logic [63:0] TBL [6] = '{
    {32'h0000_0020, 32'h0000_1005},
    {32'h0000_1008, 32'h0000_100C},
    {32'h0000_0404, 32'h0000_1002},
    {32'h0000_0000, SPUR},
    {32'h8000_0002, 32'h0000_101F},
    {32'h0080_8080, 32'h0000_1007}
  };

  irq_vector_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .srcIn(srcIn),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #2 d = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 irq", {31'b0, irqOut}, 0);
    chk("R1 fiq", {31'b0, fiqOut}, 0);
    rd(9'h110, d); chk("R1 mask", d, 0);
    rd(9'h108, d); chk("R1 status", d, 0);
    rd(9'h114, d); chk("R1 core", d, 0);
    rd(9'h090, d); chk("R1 vector", d, 0);
    rd(9'h010, d); chk("R1 mode", d, 0);
    rd(9'h134, d); chk("R1 spurious", d, 0);

    for (int i = 0; i < 32; i++) begin
      wr(9'(4 * i), (32'd2 << 5) | 32'(i % 8));
      wr(9'(9'h080 + 4 * i), 32'h1000 + 32'(i));
    end
    wr(9'h134, SPUR);
    wr(9'h120, 32'hFFFF_FFFE);

    for (int k = 0; k < 6; k++) begin
      srcIn = TBL[k][63:32];
      tick(4);
      rd(9'h100, d); chk("R4 R5 table vector", d, TBL[k][31:0]);
      rd(9'h108, d);
      chk("R6 table status", d, (TBL[k][31:0] == SPUR) ? 0 : TBL[k][31:0] - 32'h1000);
      rd(9'h114, d); chk("R5 line dropped", d, 0);
      wr(9'h130, 0);
      srcIn = '0;
      tick(4);
    end

    // nesting R6 R7
    srcIn = 32'h0000_0008; tick(4);
    rd(9'h100, d); chk("R5 nest outer", d, 32'h1003);
    srcIn |= 32'h0000_0800; tick(4);
    rd(9'h114, d); chk("R6 equal priority no preempt", d, 0);
    srcIn |= 32'h0000_2000; tick(4);
    rd(9'h114, d); chk("R6 higher preempts", d, 2);
    rd(9'h100, d); chk("R5 nest inner", d, 32'h100D);
    rd(9'h108, d); chk("R6 inner status", d, 13);
    wr(9'h130, 0);
    rd(9'h108, d); chk("R7 status after pop", d, 3);
    rd(9'h114, d); chk("R7 request again", d, 2);
    srcIn = '0; tick(4);
    wr(9'h130, 0);
    rd(9'h108, d); chk("R7 empty status", d, 0);

    // spurious nested R8
    srcIn = 32'h0000_0008; tick(4);
    rd(9'h100, d); chk("R5 outer for spurious", d, 32'h1003);
    srcIn = '0; tick(4);
    rd(9'h100, d); chk("R8 spurious vector", d, SPUR);
    rd(9'h108, d); chk("R8 spurious status", d, 0);
    wr(9'h130, 0);
    rd(9'h108, d); chk("R8 outer survives", d, 3);
    wr(9'h130, 0);
    rd(9'h108, d); chk("R8 final pop", d, 0);

    // rising edge R3 R5
    wr(9'h050, (32'd3 << 5) | 32'd4);
    rd(9'h050, d); chk("R3 mode readback", d, 32'h64);
    srcIn = 32'h0010_0000; tick(4);
    rd(9'h114, d); chk("R3 edge request", d, 2);
    rd(9'h10C, d); chk("R3 edge pending", d, 32'h0010_0000);
    rd(9'h100, d); chk("R5 edge vector", d, 32'h1014);
    wr(9'h130, 0);
    rd(9'h114, d); chk("R5 edge latch cleared", d, 0);
    srcIn = '0; tick(4);

    // set / clear R2
    wr(9'h12C, 32'h0010_0000);
    rd(9'h10C, d); chk("R2 set pending", d, 32'h0010_0000);
    rd(9'h114, d); chk("R2 set raises", d, 2);
    wr(9'h128, 32'h0010_0000);
    rd(9'h114, d); chk("R2 clear drops", d, 0);

    // zero write, disable R2
    wr(9'h124, 0);
    rd(9'h110, d); chk("R2 zero disable", d, 32'hFFFF_FFFE);
    wr(9'h124, 32'h20);
    rd(9'h110, d); chk("R2 disable bit", d, 32'hFFFF_FFDE);
    srcIn = 32'h20; tick(4);
    rd(9'h114, d); chk("R2 masked source", d, 0);
    wr(9'h120, 32'h20);
    rd(9'h114, d); chk("R2 enable raises", d, 2);
    srcIn = '0; tick(4);

    // falling edge R3
    wr(9'h024, (32'd1 << 5) | 32'd6);
    srcIn = 32'h200; tick(4);
    rd(9'h114, d); chk("R3 no hit on rise", d, 0);
    srcIn = '0; tick(4);
    rd(9'h114, d); chk("R3 fall request", d, 2);
    rd(9'h100, d); chk("R3 fall vector", d, 32'h1009);
    wr(9'h130, 0);

    // fast source R9 R10
    wr(9'h120, 32'h1);
    srcIn = 32'h1; tick(4);
    rd(9'h114, d); chk("R10 fast only", d, 1);
    chk("R9 fast port", {30'b0, irqOut, fiqOut}, 1);
    rd(9'h104, d); chk("R9 fast vector", d, 32'h1000);
    srcIn = '0; tick(4);
    rd(9'h104, d); chk("R9 fast spurious", d, SPUR);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule